// File: doc/BRIEF.md
# Indexed Byte-Window Register Port

This block is a byte-wide host bus slave. It gives a narrow bus access to a bank of 32-bit internal registers through two visible locations. A select input chooses one of them. With select low, the access goes to an 8-bit index register. With select high, the access goes to the 32-bit register that the index names. Two address bits choose the byte lane of that register. The block samples chip select, the read strobe and the write strobe on its own clock. A write is committed when a registered low-to-high transition of the write strobe is seen while chip select was asserted.

Downstream logic sees a plain register-file port: index, byte enables, replicated write data, a one-cycle write pulse and a 32-bit read-data return. The implemented index range holds a table of paired entries, and each entry takes two consecutive indexes. The block decodes which entry and which half the index points at, so the storage behind it can stay a simple array. Indexes outside the range read as zero and cannot be written. The data bus is driven only while a read is active, and never during reset.

Top module: `idxwin_port`

## Requirements
- R1: While `rst` is high, `d_oe` is 0. After reset the index register holds 0.
- R2: With `sel_data`=0, a committed write stores the bus byte in the index register for any `addr`. A read with `sel_data`=0 returns the stored index for any `addr`.
- R3: With `sel_data`=1, a committed write to an implemented index drives `rf_be` = 1 << `addr`, `rf_wdata` = the bus byte copied into all four lanes, and `rf_index` = the index register.
- R4: A write commits once per low-to-high transition of `wr_n`. `rf_we` is high for exactly one cycle, the cycle that follows the first clock edge that samples `wr_n` high after it was sampled low. The length of the low phase does not change this.
- R5: When `cs_n` is high, strobes have no effect: `rf_we` stays 0, the index is unchanged and `d_oe` stays 0.
- R6: A read (`cs_n`=0, `rd_n`=0, `sel_data`=1) drives byte `addr` of `rf_rdata` (bits 8*addr+7..8*addr) on `d_out` with `d_oe`=1. Both are valid from the second rising clock edge after the pins are applied.
- R7: `d_oe` returns to 0 by the second rising edge after the read strobe or chip select is released.
- R8: Indexes BASE to BASE+2*ENTRIES-1 (defaults 0x10 to 0x3F) are implemented, and `rf_hit` flags them. Entry n uses index BASE+2n for its low half and BASE+2n+1 for its high half. `rf_entry` = (index-BASE)/2 and `rf_upper` = 1 on the high half.
- R9: For an index outside the implemented range, a window read returns 0x00 whatever `rf_rdata` holds, and a window write produces no `rf_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Asynchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low, committed on its rising edge |
| sel_data | input | 1 | 0 selects the index register, 1 the data window |
| addr | input | 2 | Byte lane within the 32-bit target |
| d_in | input | 8 | Bus data into the block |
| d_out | output | 8 | Bus data out of the block |
| d_oe | output | 1 | Drive enable for the data bus |
| rf_index | output | 8 | Current index register |
| rf_hit | output | 1 | Index lies in the implemented range |
| rf_entry | output | ENT_W | Table entry the index points at |
| rf_upper | output | 1 | Index points at the high half of its entry |
| rf_we | output | 1 | One-cycle write pulse to the register file |
| rf_be | output | 4 | Byte enables of the write |
| rf_wdata | output | 32 | Write data, bus byte in every lane |
| rf_rdata | input | 32 | Read data of the register at `rf_index` |

## Verification
Every cycle, the assertions check these properties: the bus is not driven just after reset; drive and write pulses occur only after chip select and the right strobe history on the pins; a write pulse is never longer than one cycle, carries a single byte enable and targets an in-range index; and an unimplemented read returns zero. Only the bench's sweeps can show that the correct byte lane of the correct register comes back, and that the index-to-entry mapping is right across the whole table. The same holds for the absence of effects when chip select is high and for the response to a long strobe.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 4;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int LANE_W  = $clog2(LANES);

  // bus pins sampled into the clock domain, active-high meaning
  typedef struct packed {
    logic              cs;
    logic              rd;
    logic              wr;
    logic              sel;
    logic [LANE_W-1:0] lane;
    logic [BYTE_W-1:0] data;
  } bus_smp_t;

  localparam bus_smp_t BUS_IDLE = '0;

  function automatic logic [LANES-1:0] lane_mask(input logic [LANE_W-1:0] lane);
    return LANES'(1) << lane;
  endfunction

  function automatic logic [BYTE_W-1:0] lane_pick(input logic [WORD_W-1:0] word,
                                                  input logic [LANE_W-1:0] lane);
    return word[BYTE_W*lane +: BYTE_W];
  endfunction

  function automatic logic [WORD_W-1:0] lane_fill(input logic [BYTE_W-1:0] b);
    return {LANES{b}};
  endfunction
endpackage

// File: rtl/idxwin_sync.sv
module idxwin_sync
  import idxwin_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic                sel_data,
  input  logic [LANE_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   d_in,
  output bus_smp_t            cur,
  output bus_smp_t            held,
  output logic                wr_commit
);
  bus_smp_t s1, s2;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      s1 <= BUS_IDLE;
      s2 <= BUS_IDLE;
    end else begin
      s1 <= '{cs: ~cs_n, rd: ~rd_n, wr: ~wr_n, sel: sel_data, lane: addr, data: d_in};
      s2 <= s1;
    end
  end

  // strobe was low last sample, high now, chip selected while low
  assign wr_commit = s2.wr & ~s1.wr & s2.cs;
  assign cur  = s1;
  assign held = s2;

  assert_single_commit_R4: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
endmodule

// File: rtl/idxwin_decode.sv
module idxwin_decode
  import idxwin_pkg::*;
#(
  parameter int BASE    = 16,
  parameter int ENTRIES = 24,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [BYTE_W-1:0] index,
  output logic              hit,
  output logic [ENT_W-1:0]  entry,
  output logic              upper
);
  localparam int SPAN = 2 * ENTRIES;

  function automatic logic in_span(input logic [BYTE_W-1:0] idx);
    return (int'(idx) >= BASE) && (int'(idx) < BASE + SPAN);
  endfunction

  function automatic int offset_of(input logic [BYTE_W-1:0] idx);
    return int'(idx) - BASE;
  endfunction

  always_comb begin
    int off;
    off   = offset_of(index);
    hit   = in_span(index);
    entry = hit ? ENT_W'(off >> 1) : '0;
    upper = hit ? off[0] : 1'b0;
  end
endmodule

// File: rtl/idxwin_rdmux.sv
module idxwin_rdmux
  import idxwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_smp_t          cur,
  input  logic [BYTE_W-1:0] index,
  input  logic              hit,
  input  logic [WORD_W-1:0] rdata,
  output logic [BYTE_W-1:0] d_out,
  output logic              d_oe
);
  logic              rd_live;
  logic [BYTE_W-1:0] rd_byte;

  assign rd_live = cur.cs & cur.rd;

  always_comb begin
    if (!cur.sel)      rd_byte = index;
    else if (hit)      rd_byte = lane_pick(rdata, cur.lane);
    else               rd_byte = '0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      d_oe  <= 1'b0;
      d_out <= '0;
    end else begin
      d_oe  <= rd_live;
      d_out <= rd_live ? rd_byte : '0;
    end
  end

  assert_unimpl_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rd_live && cur.sel && !hit) |-> (d_out == '0));
endmodule

// File: rtl/idxwin_port.sv
module idxwin_port
  import idxwin_pkg::*;
#(
  parameter int BASE    = 16,
  parameter int ENTRIES = 24,
  localparam int ENT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               sel_data,
  input  logic [1:0]         addr,
  input  logic [7:0]         d_in,
  output logic [7:0]         d_out,
  output logic               d_oe,
  output logic [7:0]         rf_index,
  output logic               rf_hit,
  output logic [ENT_W-1:0]   rf_entry,
  output logic               rf_upper,
  output logic               rf_we,
  output logic [3:0]         rf_be,
  output logic [31:0]        rf_wdata,
  input  logic [31:0]        rf_rdata
);
  localparam int LAST = BASE + 2 * ENTRIES - 1;

  bus_smp_t          cur, held;
  logic              wr_commit;
  logic              idx_load;
  logic [BYTE_W-1:0] idx_q;

  idxwin_sync u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .sel_data(sel_data), .addr(addr), .d_in(d_in),
    .cur(cur), .held(held), .wr_commit(wr_commit)
  );

  idxwin_decode #(.BASE(BASE), .ENTRIES(ENTRIES)) u_dec (
    .index(idx_q), .hit(rf_hit), .entry(rf_entry), .upper(rf_upper)
  );

  idxwin_rdmux u_rd (
    .clk(clk), .rst(rst), .cur(cur), .index(idx_q), .hit(rf_hit),
    .rdata(rf_rdata), .d_out(d_out), .d_oe(d_oe)
  );

  assign idx_load = wr_commit & ~held.sel;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           idx_q <= '0;
    else if (idx_load) idx_q <= held.data;
  end

  assign rf_index = idx_q;
  assign rf_we    = wr_commit & held.sel & rf_hit;
  assign rf_be    = rf_we ? lane_mask(held.lane) : '0;
  assign rf_wdata = lane_fill(held.data);

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !d_oe);
  assert_drive_needs_read_R6: assert property (@(posedge clk) disable iff (rst)
    d_oe |-> ($past(cs_n, 2) == 1'b0 && $past(rd_n, 2) == 1'b0));
  assert_we_after_edge_R5: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($past(cs_n, 2) == 1'b0 && $past(wr_n, 2) == 1'b0 && $past(wr_n) == 1'b1));
  assert_one_lane_R3: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> ($countones(rf_be) == 1));
  assert_we_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (int'(rf_index) >= BASE && int'(rf_index) <= LAST));
  assert_index_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(idx_load) |-> $stable(rf_index));
endmodule

// File: tb/idxwin_port_bench.sv
module idxwin_port_bench;
  localparam int BASE = 16, ENTRIES = 24, ENT_W = 5, SPAN = 2 * ENTRIES;

  logic clk = 0, rst = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1, sel_data = 0;
  logic [1:0] addr = 0;
  logic [7:0] d_in = 0, d_out, rf_index;
  logic d_oe, rf_hit, rf_upper, rf_we;
  logic [ENT_W-1:0] rf_entry;
  logic [3:0] rf_be;
  logic [31:0] rf_wdata, rf_rdata;

  int checks = 0, fails = 0, we_cnt = 0;
  logic [3:0]  last_be;
  logic [31:0] last_wd;
  logic [31:0] mem [SPAN];

  always #10 clk = ~clk;

  idxwin_port #(.BASE(BASE), .ENTRIES(ENTRIES)) u_idxwin_port (.*);

  function automatic bit in_rng(input logic [7:0] i);
    return int'(i) >= BASE && int'(i) < BASE + SPAN;
  endfunction

  assign rf_rdata = in_rng(rf_index) ? mem[int'(rf_index) - BASE] : 32'hDEADBEEF;

  always @(posedge clk) if (rf_we) begin
    we_cnt++;
    last_be = rf_be;
    last_wd = rf_wdata;
    for (int b = 0; b < 4; b++)
      if (rf_be[b] && in_rng(rf_index)) mem[int'(rf_index) - BASE][8*b +: 8] = rf_wdata[8*b +: 8];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [1:0] a, input logic [7:0] d,
                           input int low_cycles = 2, input logic cs = 1'b1);
    @(negedge clk); cs_n = ~cs; sel_data = sel; addr = a; d_in = d; wr_n = 0;
    repeat (low_cycles) @(negedge clk);
    wr_n = 1;
    @(negedge clk); cs_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic sel, input logic [1:0] a, output logic [7:0] d,
                          output logic oe, input logic cs = 1'b1);
    @(negedge clk); cs_n = ~cs; sel_data = sel; addr = a; rd_n = 0;
    repeat (2) @(negedge clk);
    d = d_out; oe = d_oe;
    rd_n = 1; cs_n = 1;
    repeat (2) @(negedge clk);
    chk("R7 oe released", {31'b0, d_oe}, 32'h0);
  endtask

  function automatic logic [7:0] pat(input int i, input int l);
    return 8'((i * 37 + l * 11 + 5) & 255);
  endfunction

  logic done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rb; logic oe; int w0;
    for (int i = 0; i < SPAN; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {31'b0, d_oe}, 32'h0);
    rst = 0;
    @(negedge clk);
    chk("R1 index reset", {24'b0, rf_index}, 32'h0);
    bus_read(0, 2'd2, rb, oe);
    chk("R1 index reads zero", {24'b0, rb}, 32'h0);

    // R2: index path, any lane
    for (int a = 0; a < 4; a++) begin
      bus_write(0, 2'(a), 8'(8'h5A + a));
      chk("R2 index store", {24'b0, rf_index}, 32'(8'h5A + a));
      bus_read(0, 2'(3 - a), rb, oe);
      chk("R2 index readback", {23'b0, oe, rb}, {23'b0, 1'b1, 8'(8'h5A + a)});
    end

    // R3/R4/R6/R8: sweep the whole table plus out-of-range indexes
    for (int k = 0; k < SPAN + 4; k++) begin
      int idx;
      idx = (k < SPAN) ? BASE + k : (k == SPAN ? 0 : k == SPAN + 1 ? BASE - 1 : k == SPAN + 2 ? BASE + SPAN : 255);
      bus_write(0, 2'd0, 8'(idx));
      chk("R8 hit", {31'b0, rf_hit}, {31'b0, 1'(k < SPAN)});
      if (k < SPAN) begin
        chk("R8 entry", 32'(rf_entry), 32'(k / 2));
        chk("R8 upper", {31'b0, rf_upper}, 32'(k % 2));
      end
      for (int l = 0; l < 4; l++) begin
        w0 = we_cnt;
        bus_write(1, 2'(l), pat(idx, l), 1 + (l % 3));
        if (k < SPAN) begin
          chk("R4 one pulse", 32'(we_cnt - w0), 32'd1);
          chk("R3 byte enable", {28'b0, last_be}, 32'(1 << l));
          chk("R3 replicated data", last_wd, {4{pat(idx, l)}});
        end else
          chk("R9 no write", 32'(we_cnt - w0), 32'd0);
      end
      for (int l = 0; l < 4; l++) begin
        bus_read(1, 2'(l), rb, oe);
        chk(k < SPAN ? "R6 lane read" : "R9 zero read", {23'b0, oe, rb},
            {23'b0, 1'b1, (k < SPAN ? pat(idx, l) : 8'h00)});
      end
    end

    // R5: chip select high blocks everything
    bus_write(0, 2'd0, 8'h20);
    w0 = we_cnt;
    bus_write(1, 2'd1, 8'hC3, 2, 1'b0);
    chk("R5 no window write", 32'(we_cnt - w0), 32'd0);
    bus_write(0, 2'd0, 8'h33, 2, 1'b0);
    chk("R5 index kept", {24'b0, rf_index}, 32'h20);
    bus_read(1, 2'd1, rb, oe, 1'b0);
    chk("R5 no drive", {31'b0, oe}, 32'h0);
    bus_read(1, 2'd1, rb, oe);
    chk("R5 data kept", {24'b0, rb}, {24'b0, pat(BASE + 16, 1)});

    // R4: a long low phase still commits once
    w0 = we_cnt;
    bus_write(1, 2'd2, 8'h99, 40);
    chk("R4 long strobe", 32'(we_cnt - w0), 32'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule